// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into an asynchronous serial bit stream. A character is written into a one-entry holding register. When the output shifter is free, the character is copied into it and sent on `txd`: first a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then the stop bits, and finally an optional idle gap. Every bit lasts `OVS` sample ticks. A sample tick is one cycle in which `samp_tick` is high, so the bit rate follows the tick source that the surrounding logic provides.

The frame shape is set by the inputs that are live when a character moves into the shifter. These inputs give the character length from 5 to 9 bits, a parity type, 1, 1.5 or 2 stop bits, and a number of extra idle bit periods after each character. For multidrop buses, an address mark strobe tags the next character written so that its parity position carries 1. Ordinary characters carry 0 in that position.

The holding register empties as soon as its character enters the shifter. Software-side logic can therefore queue the next character while the current one is still on the line, and frames follow each other with no extra gap.

Top module: `sertx_frame_core`

## Requirements
- R1: After `rst`, `txd` is 1 (line idle) and `ready` is 1.
- R2: A frame starts with one low start bit, followed by the data bits least significant first. The length is `len_code`+5 for codes 0 to 3 and 8 for codes 4 to 7. `nine_bit`=1 forces 9 bits whatever `len_code` is.
- R3: The parity bit follows the data bits. `par_mode` 0 gives even parity (the data ones plus the parity bit count even), 1 gives odd parity, 2 a constant 0, 3 a constant 1, and 6 the multidrop mark. Codes 4, 5 and 7 send no parity bit.
- R4: In multidrop mode (6), a character accepted at or after an `addr_mark` pulse carries 1 in the parity position. Each mark applies to one character only, so later characters carry 0. `tx_reset` discards a mark that is still waiting.
- R5: The line is high after the last payload bit for 1 bit (`stop_code` 0), 1.5 bits (1) or 2 bits (2 or 3). Half a bit is `OVS`/2 sample ticks.
- R6: After the stop bits, `guard_bits` extra bit periods of idle high follow. A queued character starts on the tick that ends this gap, so consecutive start edges are (1+payload bits)·`OVS` + (stop halves + 2·`guard_bits`)·`OVS`/2 ticks apart.
- R7: Each bit lasts `OVS` sample ticks, and `txd` changes only on cycles with `samp_tick` high (or on reset and load).
- R8: A write (`wr_en`) is accepted only while `ready` is 1. A write while `ready` is 0 is ignored. `ready` falls in the cycle after an accepted write. If the shifter is idle, it rises again one cycle later, together with the start bit.
- R9: `tx_reset` aborts the frame in progress and discards the held character. In the next cycle `txd` is 1 and `ready` is 1, and no frame follows until a new write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | Sample tick enable, `OVS` ticks per bit |
| len_code | input | 3 | Character length minus 5 |
| nine_bit | input | 1 | Selects 9-bit characters |
| par_mode | input | 3 | Parity type code |
| stop_code | input | 2 | Stop length code |
| guard_bits | input | GW | Extra idle bit periods after each character |
| tx_reset | input | 1 | Transmitter reset command |
| addr_mark | input | 1 | Marks the next character as an address |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| ready | output | 1 | Holding register can take a character |
| txd | output | 1 | Serial output, idle high |

## Verification
The start bit appears, and `ready` returns high, on the second clock edge after a write to an idle transmitter. `ready` drops on the first edge. The bench samples both at negative edges, one and two cycles after the write. Each later bit is due exactly `OVS` ticks after the previous one, so the bench locates the falling edge of the start bit and then samples in the middle of every bit period. The gap between two start edges is exact in ticks, and with a tick in every cycle the bench compares it with the R6 formula to the cycle. After an ignored write or a `tx_reset`, the bench watches the line for several frame lengths to confirm that no frame goes out.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 9;
    localparam int PAY_W  = 10;

    localparam logic [2:0] PAR_EVEN  = 3'd0;
    localparam logic [2:0] PAR_ODD   = 3'd1;
    localparam logic [2:0] PAR_ZERO  = 3'd2;
    localparam logic [2:0] PAR_ONE   = 3'd3;
    localparam logic [2:0] PAR_MDROP = 3'd6;

    typedef struct packed {
        logic [PAY_W-1:0] bits;   // data then parity, LSB sent first
        logic [3:0]       count;  // number of payload bits
    } payload_t;

    typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_TAIL} sh_state_e;

    function automatic logic [3:0] char_len(input logic [2:0] code, input logic nine);
        if (nine)            return 4'd9;
        else if (code > 3'd3) return 4'd8;
        else                 return 4'd5 + {1'b0, code};
    endfunction

    function automatic logic [2:0] stop_halves(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd2;
            2'd1:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic payload_t build_payload(input logic [CHAR_W-1:0] d,
                                               input logic [2:0] lc,
                                               input logic nine,
                                               input logic [2:0] pm,
                                               input logic amark);
        payload_t   r;
        logic [3:0] n;
        logic       p;
        logic       use_p;
        n      = char_len(lc, nine);
        r.bits = '0;
        for (int i = 0; i < CHAR_W; i++)
            if (i < int'(n)) r.bits[i] = d[i];
        use_p = 1'b1;
        case (pm)
            PAR_EVEN:  p = ^r.bits;
            PAR_ODD:   p = ~(^r.bits);
            PAR_ZERO:  p = 1'b0;
            PAR_ONE:   p = 1'b1;
            PAR_MDROP: p = amark;
            default: begin
                p     = 1'b0;
                use_p = 1'b0;
            end
        endcase
        if (use_p) r.bits[n] = p;
        r.count = n + {3'b0, use_p};
        return r;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              addr_mark,
    input  logic              take,
    output logic              valid,
    output logic [CHAR_W-1:0] data,
    output logic              amark
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= 1'b0;
            data  <= '0;
            amark <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (take) valid <= 1'b0;
            if (wr_en && !valid) begin
                valid <= 1'b1;
                data  <= wr_data;
                amark <= pend | addr_mark;
                pend  <= 1'b0;
            end else if (addr_mark) begin
                pend <= 1'b1;
            end
        end
    end

    // R8
    wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && valid) |=> $stable(data));

    // R8
    wr_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !valid && !clr) |=> valid);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int HW  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          samp_tick,
    input  logic          hold_valid,
    input  payload_t      pl,
    input  logic [HW-1:0] tail_halves,
    output logic          take,
    output logic          txd
);

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    sh_state_e        state;
    logic [CW-1:0]    tcnt;
    logic [PAY_W-1:0] sh;
    logic [3:0]       left;
    logic [HW-1:0]    hleft;
    logic [HW-1:0]    hcfg;
    logic             bit_end;
    logic             half_end;
    logic             tail_done;

    assign bit_end   = samp_tick && (tcnt == CW'(OVS - 1));
    assign half_end  = samp_tick && (tcnt == CW'(HALF - 1));
    assign tail_done = (state == SH_TAIL) && half_end && (hleft == HW'(1));
    assign take      = hold_valid && !clr && ((state == SH_IDLE) || tail_done);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= SH_IDLE;
            txd   <= 1'b1;
            tcnt  <= '0;
            sh    <= '0;
            left  <= '0;
            hleft <= '0;
            hcfg  <= '0;
        end else if (take) begin
            state <= SH_BITS;
            txd   <= 1'b0;
            tcnt  <= '0;
            sh    <= pl.bits;
            left  <= pl.count;
            hcfg  <= tail_halves;
        end else begin
            case (state)
                SH_BITS: if (samp_tick) begin
                    if (bit_end) begin
                        tcnt <= '0;
                        if (left != 4'd0) begin
                            txd  <= sh[0];
                            sh   <= sh >> 1;
                            left <= left - 4'd1;
                        end else begin
                            txd   <= 1'b1;
                            state <= SH_TAIL;
                            hleft <= hcfg;
                        end
                    end else begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                SH_TAIL: if (samp_tick) begin
                    if (half_end) begin
                        tcnt  <= '0;
                        hleft <= hleft - HW'(1);
                        if (hleft == HW'(1)) state <= SH_IDLE;
                    end else begin
                        tcnt <= tcnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);

    // R5
    tail_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SH_TAIL) |-> txd);

    // R7
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (state != SH_IDLE && !samp_tick && !clr && !take) |=> $stable(txd));

    // R7
    tcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(tcnt) < OVS);

endmodule

// File: rtl/sertx_frame_core.sv
module sertx_frame_core
    import sertx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int GW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          samp_tick,
    input  logic [2:0]    len_code,
    input  logic          nine_bit,
    input  logic [2:0]    par_mode,
    input  logic [1:0]    stop_code,
    input  logic [GW-1:0] guard_bits,
    input  logic          tx_reset,
    input  logic          addr_mark,
    input  logic          wr_en,
    input  logic [8:0]    wr_data,
    output logic          ready,
    output logic          txd
);

    localparam int HW = GW + 2;

    logic              hvalid;
    logic [CHAR_W-1:0] hdata;
    logic              hmark;
    logic              take;
    payload_t          pl;
    logic [HW-1:0]     tail_halves;

    assign ready       = !hvalid;
    assign pl          = build_payload(hdata, len_code, nine_bit, par_mode, hmark);
    assign tail_halves = HW'(stop_halves(stop_code)) + {1'b0, guard_bits, 1'b0};

    sertx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_reset),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .addr_mark (addr_mark),
        .take      (take),
        .valid     (hvalid),
        .data      (hdata),
        .amark     (hmark)
    );

    sertx_shift #(.OVS(OVS), .HW(HW)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .clr         (tx_reset),
        .samp_tick   (samp_tick),
        .hold_valid  (hvalid),
        .pl          (pl),
        .tail_halves (tail_halves),
        .take        (take),
        .txd         (txd)
    );

    // R9
    txrst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_reset |=> (txd && ready));

endmodule

// File: tb/sertx_frame_core_tb_top.sv
`timescale 1ns/1ps
module sertx_frame_core_tb_top;

    localparam int OVS = 16;
    localparam int GW  = 8;

    typedef struct packed {
        logic [8:0] data;
        logic [2:0] len;
        logic       nine;
        logic [2:0] par;
        logic [1:0] stop;
        logic [7:0] guard;
        logic       addr;
        logic [1:0] div;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{9'h0B5, 3'd0, 1'b0, 3'd0, 2'd0, 8'd0, 1'b0, 2'd1},
        '{9'h04C, 3'd2, 1'b0, 3'd1, 2'd1, 8'd0, 1'b0, 2'd1},
        '{9'h0A5, 3'd3, 1'b0, 3'd2, 2'd2, 8'd2, 1'b0, 2'd1},
        '{9'h03C, 3'd3, 1'b0, 3'd3, 2'd0, 8'd1, 1'b0, 2'd1},
        '{9'h1A3, 3'd1, 1'b1, 3'd4, 2'd0, 8'd3, 1'b0, 2'd1},
        '{9'h05A, 3'd1, 1'b0, 3'd6, 2'd1, 8'd0, 1'b1, 2'd1},
        '{9'h1F7, 3'd0, 1'b1, 3'd0, 2'd2, 8'd1, 1'b0, 2'd3},
        '{9'h0C9, 3'd7, 1'b0, 3'd5, 2'd3, 8'd0, 1'b0, 2'd2}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          samp_tick = 1'b1;
    logic [2:0]    len_code = 3'd3;
    logic          nine_bit = 1'b0;
    logic [2:0]    par_mode = 3'd4;
    logic [1:0]    stop_code = 2'd0;
    logic [GW-1:0] guard_bits = '0;
    logic          tx_reset = 1'b0;
    logic          addr_mark = 1'b0;
    logic          wr_en = 1'b0;
    logic [8:0]    wr_data = '0;
    logic          ready;
    logic          txd;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int div_r = 1;
    int tdc = 0;

    sertx_frame_core #(.OVS(OVS), .GW(GW)) dut_i (
        .clk(clk), .rst(rst), .samp_tick(samp_tick), .len_code(len_code),
        .nine_bit(nine_bit), .par_mode(par_mode), .stop_code(stop_code),
        .guard_bits(guard_bits), .tx_reset(tx_reset), .addr_mark(addr_mark),
        .wr_en(wr_en), .wr_data(wr_data), .ready(ready), .txd(txd)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        samp_tick <= (tdc == 0);
        tdc       <= (tdc + 1 >= div_r) ? 0 : tdc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected frame {stop, payload, start}, built from R2/R3
    task automatic exp_frame(input logic [8:0] d, input logic [2:0] lc, input logic nine,
                             input logic [2:0] pm, input logic am,
                             output int nb, output logic [11:0] fr);
        int n;
        logic [9:0] pay;
        logic p;
        bit has_p;
        n = nine ? 9 : ((lc > 3) ? 8 : int'(lc) + 5);
        pay = '0;
        for (int i = 0; i < n; i++) pay[i] = d[i];
        has_p = 1'b1;
        case (pm)
            3'd0: p = ^pay;
            3'd1: p = ~(^pay);
            3'd2: p = 1'b0;
            3'd3: p = 1'b1;
            3'd6: p = am;
            default: begin p = 1'b0; has_p = 1'b0; end
        endcase
        if (has_p) pay[n] = p;
        nb = n + (has_p ? 1 : 0);
        fr = '0;
        for (int i = 0; i < nb; i++) fr[i+1] = pay[i];
        fr[nb+1] = 1'b1;
    endtask

    task automatic grab(input int nb, input int dv, output logic [11:0] obs, output int tf);
        int w;
        w = 0;
        obs = '0;
        while (txd && w < 4000) begin
            @(negedge clk);
            w++;
        end
        tf = cyc;
        repeat (OVS * dv / 2) @(negedge clk);
        obs[0] = txd;
        for (int i = 1; i <= nb + 1; i++) begin
            repeat (OVS * dv) @(negedge clk);
            obs[i] = txd;
        end
    endtask

    task automatic quiet(input int ncyc, input string req);
        int lows;
        lows = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (!txd) lows++;
        end
        chk(lows == 0, req, lows, 0);
    endtask

    task automatic pulse_txrst();
        tx_reset = 1'b1;
        @(negedge clk);
        tx_reset = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [11:0] e1, e2, o1, o2;
        int nb, nb2, t1, t2, halves;
        logic [8:0] d2;
        len_code = v.len; nine_bit = v.nine; par_mode = v.par;
        stop_code = v.stop; guard_bits = v.guard; div_r = int'(v.div);
        pulse_txrst();
        repeat (3) @(negedge clk);
        if (v.addr) begin
            addr_mark = 1'b1;
            @(negedge clk);
            addr_mark = 1'b0;
        end
        d2 = ~v.data;
        exp_frame(v.data, v.len, v.nine, v.par, v.addr, nb, e1);
        exp_frame(d2, v.len, v.nine, v.par, 1'b0, nb2, e2);
        wr_data = v.data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        fork
            begin
                grab(nb, int'(v.div), o1, t1);
                grab(nb2, int'(v.div), o2, t2);
            end
            begin
                while (!ready) @(negedge clk);
                wr_data = d2; wr_en = 1'b1;
                @(negedge clk);
                wr_en = 1'b0;
            end
        join
        chk(o1 == e1, "R2/R3/R5 frame one", int'(o1), int'(e1));
        chk(o2 == e2, "R2/R3/R4 frame two", int'(o2), int'(e2));
        if (v.div == 2'd1) begin
            halves = (v.stop == 2'd0) ? 2 : ((v.stop == 2'd1) ? 3 : 4);
            halves += 2 * int'(v.guard);
            chk(t2 - t1 == (1 + nb) * OVS + halves * OVS / 2, "R6/R7 start spacing",
                t2 - t1, (1 + nb) * OVS + halves * OVS / 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] e, o;
        int nb, t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8: ready timing and ignored write
        len_code = 3'd3; nine_bit = 1'b0; par_mode = 3'd4;
        stop_code = 2'd0; guard_bits = '0; div_r = 1;
        pulse_txrst();
        repeat (3) @(negedge clk);
        wr_data = 9'h03A; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(ready == 1'b0, "R8 ready low after write", int'(ready), 0);
        @(negedge clk);
        chk(ready == 1'b1, "R8 ready back high", int'(ready), 1);
        chk(txd == 1'b0, "R8 start bit with ready", int'(txd), 0);
        wr_data = 9'h0C5; wr_en = 1'b1;
        @(negedge clk);
        wr_data = 9'h0FF;
        @(negedge clk);
        wr_en = 1'b0;
        chk(ready == 1'b0, "R8 still full", int'(ready), 0);
        repeat (OVS * 10) @(negedge clk);
        exp_frame(9'h0C5, 3'd3, 1'b0, 3'd4, 1'b0, nb, e);
        grab(nb, 1, o, t);
        chk(o == e, "R8 queued char kept, extra write ignored", int'(o), int'(e));
        quiet(OVS * 30, "R8 no third frame");

        // R9: reset mid-frame drops held char
        wr_data = 9'h055; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        wr_data = 9'h0AA; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (40) @(negedge clk);
        pulse_txrst();
        chk(txd == 1'b1, "R9 line high after reset", int'(txd), 1);
        chk(ready == 1'b1, "R9 ready after reset", int'(ready), 1);
        quiet(OVS * 30, "R9 no frame after reset");

        // R4: pending address mark cleared by tx_reset
        par_mode = 3'd6;
        addr_mark = 1'b1;
        @(negedge clk);
        addr_mark = 1'b0;
        pulse_txrst();
        @(negedge clk);
        wr_data = 9'h081; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        exp_frame(9'h081, 3'd3, 1'b0, 3'd6, 1'b0, nb, e);
        grab(nb, 1, o, t);
        chk(o == e, "R4 mark dropped by tx_reset", int'(o), int'(e));

        repeat (OVS * 4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule